// File: doc/BRIEF.md
# IN Endpoint Transmit Buffer with Commit and Ping-Pong Banks

This block stages outgoing packet data for two USB IN endpoints. A processor pushes payload in 32-bit words and then commits it by writing the packet's byte count. Only a committed bank is visible to the USB side. The serial engine then pulls the packet one byte at a time and reports the host's reply. An ACK releases the bank. A timeout rewinds the packet so the same bytes are sent again.

Endpoint A is an interrupt endpoint with one 64-byte bank. Endpoint B is a bulk endpoint with two 256-byte banks used in ping-pong fashion. The processor fills one bank while the other waits for transmission. A status word reports, per endpoint, whether any committed data is waiting. A sticky flag per endpoint records a completed, acknowledged transfer. A flush input per endpoint discards everything that endpoint holds.

Top module: `usb_in_ep_buf`

## Requirements
- R1: After reset, `data_sts` is 0, `txc_flag` is 0, and `usb_empty` is 1 for both endpoints.
- R2: Written words are not transmittable until a commit. A commit sets `data_sts` bit 5 for endpoint A (`cpu_ep`=0) or bit 4 for endpoint B (`cpu_ep`=1), and every other status bit reads 0.
- R3: Within a word, byte 0 is `cpu_wdata[7:0]` and byte 3 is `cpu_wdata[31:24]`. Bytes are presented on `usb_rdata` in write order, one per `usb_rd` pulse. `usb_len` shows the committed count.
- R4: A committed count above the bank size is limited to the bank size: 64 for endpoint A and 256 for each bank of endpoint B.
- R5: `usb_ack` on a waiting packet releases its bank and sets that endpoint's `txc_flag` bit (bit 0 for A, bit 1 for B) on the same edge. A `cpu_txc_clr` bit clears that flag.
- R6: `usb_timeout` returns the read position to the first byte of the current packet and keeps the packet pending.
- R7: `usb_empty` is 1 whenever the endpoint selected by `usb_ep` has no committed packet, so the engine answers NAK.
- R8: Endpoint B accepts a second packet while the first is pending. Packets are delivered in commit order. Its status bit stays 1 until both banks are drained.
- R9: A commit or a data write while no bank of that endpoint is free is ignored.
- R10: A `cpu_flush` bit (bit 0 for A, bit 1 for B) empties every bank of that endpoint and leaves the other endpoint untouched.
- R11: `usb_ack` while no packet is waiting has no effect on the flags or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ep | input | 1 | Endpoint targeted by a write or commit (0 = A, 1 = B) |
| cpu_wr_en | input | 1 | Write one data word |
| cpu_wdata | input | 32 | Data word |
| cpu_commit | input | 1 | Commit the filling bank with `cpu_bytes` |
| cpu_bytes | input | 10 | Packet byte count |
| cpu_flush | input | 2 | Per-endpoint flush |
| cpu_txc_clr | input | 2 | Per-endpoint clear of the transfer-complete flag |
| usb_ep | input | 1 | Endpoint addressed by the USB side |
| usb_rd | input | 1 | Advance to the next byte |
| usb_ack | input | 1 | Host acknowledged the packet |
| usb_timeout | input | 1 | No handshake was received; resend |
| usb_rdata | output | 8 | Current byte of the packet being sent |
| usb_len | output | 10 | Byte count of the packet being sent |
| usb_empty | output | 1 | No committed packet on the selected endpoint |
| data_sts | output | 32 | Data-waiting status word |
| txc_flag | output | 2 | Transfer-complete flags |

## Verification
Embedded assertions guard several per-cycle properties:
- the read position never passes the packet length, and a held packet never exceeds its bank;
- a flush always leaves the endpoint empty on the next cycle, and a timeout rewinds without releasing the bank;
- a commit with no free bank changes no bank;
- the transfer flag follows every accepted ACK, and endpoint B's status falls only after an ACK or a flush.

Byte ordering, length limiting, commit-order delivery across two banks, NAK signalling before commit, and the isolation of one endpoint's flush from the other can only be shown by the directed scenarios. Those scenarios compare the delivered bytes and status words against values derived from the requirements.

// File: rtl/inep_pkg.sv
package inep_pkg;

    localparam int CNT_W            = 10;
    localparam int INT_BANK_BYTES   = 64;
    localparam int BULK_TOTAL_BYTES = 512;
    localparam int BULK_NBANK       = 2;
    localparam int BULK_BANK_BYTES  = BULK_TOTAL_BYTES / BULK_NBANK;
    localparam int STS_W            = 32;
    localparam int STS_INT_BIT      = 5;
    localparam int STS_BULK_BIT     = 4;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] len;
    } bank_t;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] cnt,
                                                   input logic [CNT_W-1:0] lim);
        return (cnt > lim) ? lim : cnt;
    endfunction

endpackage

// File: rtl/inep_bank_ram.sv
module inep_bank_ram #(
    parameter int BANK_BYTES = 64
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [$clog2(BANK_BYTES/4)-1:0] waddr,
    input  logic [31:0]                   wdata,
    input  logic [$clog2(BANK_BYTES)-1:0] raddr,
    output logic [7:0]                    rdata
);
    localparam int AW = $clog2(BANK_BYTES/4);

    logic [7:0] mem [BANK_BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < 4; b++) begin
                mem[{waddr, 2'(b)}] <= wdata[8*b +: 8];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/inep_core.sv
module inep_core
    import inep_pkg::*;
#(
    parameter int NBANK      = 1,
    parameter int BANK_BYTES = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_cnt,
    input  logic             flush,
    input  logic             rd,
    input  logic             ack,
    input  logic             timeout,
    output logic [7:0]       rdata,
    output logic [CNT_W-1:0] pkt_len,
    output logic             avail,
    output logic             de,
    output logic             ack_done
);
    localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam int WORDS = BANK_BYTES / 4;
    localparam int WP_W  = $clog2(WORDS + 1);
    localparam int AW    = $clog2(WORDS);
    localparam int RAW   = $clog2(BANK_BYTES);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(BANK_BYTES);

    bank_t            bank [NBANK];
    logic [IDX_W-1:0] fill_idx, rd_idx;
    logic [WP_W-1:0]  wptr;
    logic [CNT_W-1:0] rptr;
    logic [NBANK-1:0] valid_vec;
    logic [7:0]       ram_rd [NBANK];
    logic             free, wr_ok, commit_ok, rd_ok;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(NBANK - 1)) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        for (int i = 0; i < NBANK; i++) valid_vec[i] = bank[i].valid;
    end

    assign free      = !bank[fill_idx].valid;
    assign wr_ok     = wr_en && !flush && free && (wptr < WP_W'(WORDS));
    assign commit_ok = commit && !flush && free;
    assign avail     = bank[rd_idx].valid;
    assign pkt_len   = bank[rd_idx].len;
    assign ack_done  = ack && !flush && avail;
    assign rd_ok     = rd && !flush && !timeout && avail && (rptr < pkt_len);
    assign de        = |valid_vec;
    assign rdata     = ram_rd[rd_idx];

    generate
        for (genvar g = 0; g < NBANK; g++) begin : g_bank
            inep_bank_ram #(.BANK_BYTES(BANK_BYTES)) u_ram (
                .clk   (clk),
                .we    (wr_ok && (fill_idx == IDX_W'(g))),
                .waddr (wptr[AW-1:0]),
                .wdata (wdata),
                .raddr (rptr[RAW-1:0]),
                .rdata (ram_rd[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < NBANK; i++) bank[i] <= '0;
            fill_idx <= '0;
            rd_idx   <= '0;
            wptr     <= '0;
            rptr     <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (commit_ok) begin
                bank[fill_idx] <= '{valid: 1'b1, len: clamp_cnt(commit_cnt, LIM)};
                fill_idx       <= next_idx(fill_idx);
                wptr           <= '0;
            end
            if (ack_done) begin
                bank[rd_idx].valid <= 1'b0;
                rd_idx             <= next_idx(rd_idx);
                rptr               <= '0;
            end else if (timeout) begin
                rptr <= '0;
            end else if (rd_ok) begin
                rptr <= rptr + 1'b1;
            end
        end
    end

    assert_rptr_bound_R3: assert property (@(posedge clk) disable iff (rst)
        avail |-> rptr <= pkt_len);
    assert_len_clamp_R4: assert property (@(posedge clk) disable iff (rst)
        avail |-> pkt_len <= LIM);
    assert_timeout_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (timeout && avail && !ack && !flush && !commit) |=> (rptr == '0 && $stable(valid_vec)));
    assert_commit_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && !free && !ack && !flush) |=> $stable(valid_vec));
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0 && !avail));

endmodule

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf
    import inep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_ep,
    input  logic             cpu_wr_en,
    input  logic [31:0]      cpu_wdata,
    input  logic             cpu_commit,
    input  logic [CNT_W-1:0] cpu_bytes,
    input  logic [1:0]       cpu_flush,
    input  logic [1:0]       cpu_txc_clr,
    input  logic             usb_ep,
    input  logic             usb_rd,
    input  logic             usb_ack,
    input  logic             usb_timeout,
    output logic [7:0]       usb_rdata,
    output logic [CNT_W-1:0] usb_len,
    output logic             usb_empty,
    output logic [STS_W-1:0] data_sts,
    output logic [1:0]       txc_flag
);
    logic [7:0]       rdata_a, rdata_b;
    logic [CNT_W-1:0] len_a, len_b;
    logic             avail_a, avail_b, de_a, de_b, done_a, done_b;

    inep_core #(.NBANK(1), .BANK_BYTES(INT_BANK_BYTES)) u_ep_a (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cpu_wr_en && !cpu_ep),
        .wdata      (cpu_wdata),
        .commit     (cpu_commit && !cpu_ep),
        .commit_cnt (cpu_bytes),
        .flush      (cpu_flush[0]),
        .rd         (usb_rd && !usb_ep),
        .ack        (usb_ack && !usb_ep),
        .timeout    (usb_timeout && !usb_ep),
        .rdata      (rdata_a),
        .pkt_len    (len_a),
        .avail      (avail_a),
        .de         (de_a),
        .ack_done   (done_a)
    );

    inep_core #(.NBANK(BULK_NBANK), .BANK_BYTES(BULK_BANK_BYTES)) u_ep_b (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cpu_wr_en && cpu_ep),
        .wdata      (cpu_wdata),
        .commit     (cpu_commit && cpu_ep),
        .commit_cnt (cpu_bytes),
        .flush      (cpu_flush[1]),
        .rd         (usb_rd && usb_ep),
        .ack        (usb_ack && usb_ep),
        .timeout    (usb_timeout && usb_ep),
        .rdata      (rdata_b),
        .pkt_len    (len_b),
        .avail      (avail_b),
        .de         (de_b),
        .ack_done   (done_b)
    );

    assign usb_rdata = usb_ep ? rdata_b : rdata_a;
    assign usb_len   = usb_ep ? len_b : len_a;
    assign usb_empty = usb_ep ? !avail_b : !avail_a;

    always_comb begin
        data_sts               = '0;
        data_sts[STS_INT_BIT]  = de_a;
        data_sts[STS_BULK_BIT] = de_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txc_flag <= '0;
        end else begin
            txc_flag[0] <= done_a | (txc_flag[0] & ~cpu_txc_clr[0]);
            txc_flag[1] <= done_b | (txc_flag[1] & ~cpu_txc_clr[1]);
        end
    end

    assert_txc_set_R5: assert property (@(posedge clk) disable iff (rst)
        (done_a || done_b) |=> (txc_flag[0] || !$past(done_a)) && (txc_flag[1] || !$past(done_b)));
    assert_bulk_de_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(data_sts[STS_BULK_BIT]) |-> $past(done_b || cpu_flush[1]));
    assert_no_ack_no_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (!done_a && !txc_flag[0]) |=> !txc_flag[0]);

endmodule

// File: tb/sim_usb_in_ep_buf.sv
module sim_usb_in_ep_buf;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_ep, cpu_wr_en, cpu_commit;
    logic [31:0] cpu_wdata;
    logic [9:0]  cpu_bytes;
    logic [1:0]  cpu_flush, cpu_txc_clr;
    logic        usb_ep, usb_rd, usb_ack, usb_timeout;
    logic [7:0]  usb_rdata;
    logic [9:0]  usb_len;
    logic        usb_empty;
    logic [31:0] data_sts;
    logic [1:0]  txc_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_in_ep_buf u0 (
        .clk(clk), .rst(rst), .cpu_ep(cpu_ep), .cpu_wr_en(cpu_wr_en),
        .cpu_wdata(cpu_wdata), .cpu_commit(cpu_commit), .cpu_bytes(cpu_bytes),
        .cpu_flush(cpu_flush), .cpu_txc_clr(cpu_txc_clr), .usb_ep(usb_ep),
        .usb_rd(usb_rd), .usb_ack(usb_ack), .usb_timeout(usb_timeout),
        .usb_rdata(usb_rdata), .usb_len(usb_len), .usb_empty(usb_empty),
        .data_sts(data_sts), .txc_flag(txc_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic ep, input logic [31:0] d);
        cpu_ep = ep; cpu_wdata = d; cpu_wr_en = 1'b1;
        @(negedge clk); cpu_wr_en = 1'b0;
    endtask

    task automatic fill(input logic ep, input logic [7:0] seed, input int nwords);
        for (int k = 0; k < nwords; k++) begin
            logic [7:0] b0;
            b0 = seed + 8'(4 * k);
            wr(ep, {b0 + 8'd3, b0 + 8'd2, b0 + 8'd1, b0});
        end
    endtask

    task automatic commit(input logic ep, input logic [9:0] n);
        cpu_ep = ep; cpu_bytes = n; cpu_commit = 1'b1;
        @(negedge clk); cpu_commit = 1'b0;
    endtask

    task automatic flush(input logic [1:0] m);
        cpu_flush = m; @(negedge clk); cpu_flush = 2'b00;
    endtask

    task automatic ack(input logic ep);
        usb_ep = ep; usb_ack = 1'b1; @(negedge clk); usb_ack = 1'b0;
    endtask

    task automatic tmo(input logic ep);
        usb_ep = ep; usb_timeout = 1'b1; @(negedge clk); usb_timeout = 1'b0;
    endtask

    task automatic txc_clr(input logic [1:0] m);
        cpu_txc_clr = m; @(negedge clk); cpu_txc_clr = 2'b00;
    endtask

    task automatic read_bytes(input logic ep, input logic [7:0] seed, input int n, input string req);
        usb_ep = ep;
        for (int i = 0; i < n; i++) begin
            chk(usb_rdata == seed + 8'(i), req, 32'(usb_rdata), 32'(seed + 8'(i)));
            usb_rd = 1'b1; @(negedge clk); usb_rd = 1'b0;
        end
    endtask

    task automatic t_reset;
        usb_ep = 1'b0; #1;
        chk(data_sts == 32'h0, "R1 status", data_sts, 32'h0);
        chk(txc_flag == 2'b00, "R1 txc", 32'(txc_flag), 32'h0);
        chk(usb_empty == 1'b1, "R1 empty A", 32'(usb_empty), 32'h1);
        usb_ep = 1'b1; #1;
        chk(usb_empty == 1'b1, "R1 empty B", 32'(usb_empty), 32'h1);
        @(negedge clk);
    endtask

    task automatic t_basic_a;
        fill(1'b0, 8'h10, 3);
        usb_ep = 1'b0; #1;
        chk(data_sts == 32'h0, "R2 not valid before commit", data_sts, 32'h0);
        chk(usb_empty == 1'b1, "R7 empty before commit", 32'(usb_empty), 32'h1);
        commit(1'b0, 10'd10);
        chk(data_sts == 32'h20, "R2 bit5 set", data_sts, 32'h20);
        chk(usb_len == 10'd10, "R3 length", 32'(usb_len), 32'd10);
        chk(usb_empty == 1'b0, "R7 not empty", 32'(usb_empty), 32'h0);
        read_bytes(1'b0, 8'h10, 10, "R3 byte order");
        ack(1'b0);
        chk(txc_flag == 2'b01, "R5 txc A set", 32'(txc_flag), 32'h1);
        chk(data_sts == 32'h0, "R5 released", data_sts, 32'h0);
        chk(usb_empty == 1'b1, "R7 empty after ack", 32'(usb_empty), 32'h1);
        txc_clr(2'b01);
        chk(txc_flag == 2'b00, "R5 txc cleared", 32'(txc_flag), 32'h0);
    endtask

    task automatic t_timeout;
        fill(1'b0, 8'h40, 2);
        commit(1'b0, 10'd8);
        read_bytes(1'b0, 8'h40, 5, "R6 first try");
        tmo(1'b0);
        chk(data_sts == 32'h20, "R6 kept", data_sts, 32'h20);
        chk(txc_flag == 2'b00, "R6 no txc", 32'(txc_flag), 32'h0);
        read_bytes(1'b0, 8'h40, 8, "R6 resend from start");
        ack(1'b0);
        txc_clr(2'b11);
    endtask

    task automatic t_clamp_full_a;
        fill(1'b0, 8'h00, 16);
        commit(1'b0, 10'd100);
        usb_ep = 1'b0; #1;
        chk(usb_len == 10'd64, "R4 clamp A", 32'(usb_len), 32'd64);
        wr(1'b0, 32'hDEADBEEF);
        commit(1'b0, 10'd3);
        chk(usb_len == 10'd64, "R9 commit ignored", 32'(usb_len), 32'd64);
        read_bytes(1'b0, 8'h00, 4, "R9 data kept");
        ack(1'b0);
        chk(data_sts == 32'h0, "R9 no phantom packet A", data_sts, 32'h0);
        chk(usb_empty == 1'b1, "R9 empty A", 32'(usb_empty), 32'h1);
        txc_clr(2'b11);
    endtask

    task automatic t_pingpong;
        fill(1'b1, 8'h80, 2);
        commit(1'b1, 10'd8);
        chk(data_sts == 32'h10, "R2 bit4 set", data_sts, 32'h10);
        fill(1'b1, 8'hA0, 1);
        commit(1'b1, 10'd4);
        fill(1'b1, 8'hC0, 1);
        commit(1'b1, 10'd4);
        usb_ep = 1'b1; #1;
        chk(usb_len == 10'd8, "R8 first packet length", 32'(usb_len), 32'd8);
        read_bytes(1'b1, 8'h80, 8, "R8 first packet data");
        ack(1'b1);
        chk(data_sts == 32'h10, "R8 status held with one bank", data_sts, 32'h10);
        chk(txc_flag == 2'b10, "R5 txc B", 32'(txc_flag), 32'h2);
        chk(usb_len == 10'd4, "R8 second packet length", 32'(usb_len), 32'd4);
        read_bytes(1'b1, 8'hA0, 4, "R8 second packet data");
        ack(1'b1);
        chk(data_sts == 32'h0, "R8 status clears when both empty", data_sts, 32'h0);
        chk(usb_empty == 1'b1, "R9 third commit ignored", 32'(usb_empty), 32'h1);
        commit(1'b1, 10'd300);
        chk(usb_len == 10'd256, "R4 clamp B", 32'(usb_len), 32'd256);
        flush(2'b10);
        txc_clr(2'b11);
    endtask

    task automatic t_flush;
        fill(1'b0, 8'h33, 1);
        commit(1'b0, 10'd4);
        fill(1'b1, 8'h55, 1);
        commit(1'b1, 10'd4);
        chk(data_sts == 32'h30, "R10 both pending", data_sts, 32'h30);
        flush(2'b10);
        chk(data_sts == 32'h20, "R10 B flushed A kept", data_sts, 32'h20);
        usb_ep = 1'b0; #1;
        chk(usb_rdata == 8'h33, "R10 A data intact", 32'(usb_rdata), 32'h33);
        flush(2'b01);
        chk(data_sts == 32'h0, "R10 A flushed", data_sts, 32'h0);
        chk(usb_empty == 1'b1, "R10 A empty", 32'(usb_empty), 32'h1);
    endtask

    task automatic t_stray_ack;
        ack(1'b0);
        ack(1'b1);
        chk(txc_flag == 2'b00, "R11 stray ack", 32'(txc_flag), 32'h0);
        chk(data_sts == 32'h0, "R11 status unchanged", data_sts, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cpu_ep = 1'b0; cpu_wr_en = 1'b0; cpu_commit = 1'b0;
        cpu_wdata = '0; cpu_bytes = '0; cpu_flush = '0; cpu_txc_clr = '0;
        usb_ep = 1'b0; usb_rd = 1'b0; usb_ack = 1'b0; usb_timeout = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic_a;
        t_timeout;
        t_clamp_full_a;
        t_pingpong;
        t_flush;
        t_stray_ack;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule